// File: doc/BRIEF.md
# Asynchronous Data-Port Access Sequencer

This block sits on the host side of a narrow asynchronous strobe bus and runs single 32-bit read and write accesses against a peripheral's data port. It drives an active-low port select, separate active-low read and write strobes, a 32-bit outgoing data word with its own output enable, and takes a 32-bit incoming data word. Every access moves a full word, so no address or byte-lane signals are produced.

The host side is a request/ready handshake. The host presents a direction bit and, for writes, a data word; the block takes the request on a clock edge where `req_ready` is high. It returns a one-cycle `done` pulse and, for reads, the captured word. The nanosecond rules of the bus are turned into whole clock cycles through module parameters. These cover select setup and hold, strobe width, write data setup and hold, and the read sampling point. They also cover the quiet period after a read in which the peripheral may still drive the bus. The last one is the minimum fall-to-fall spacing of consecutive strobes, which is longer when `full_duplex` is high.

Top module: `dport_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `cs_n`, `rd_n` and `wr_n` are 1 and `bus_oe` and `done` are 0. After reset, `req_ready` is 1.
- R2: `cs_n` goes low one clock cycle (10 ns, at least 2 ns) before the strobe of the access falls.
- R3: The strobe stays low for exactly 3 cycles (30 ns).
- R4: `cs_n` stays low for one cycle (10 ns, at least 5 ns) after the strobe rises.
- R5: A read captures `bus_din` on the clock edge that raises `rd_n`, 30 ns after its fall. The word appears on `rdata` while `done` is high.
- R6: For a write, `bus_dout` carries the request word from the cycle `cs_n` falls. It holds that word at least 10 ns before and at least 5 ns after `wr_n` rises.
- R7: For a write, `bus_oe` rises together with the fall of `cs_n` and falls exactly one cycle after `cs_n` rises.
- R8: `bus_oe` is never high while `rd_n` is low. It is also never high during the 2 cycles after `rd_n` rises, while the peripheral may still drive data.
- R9: With `full_duplex` low, back-to-back accesses have their strobes falling exactly 8 cycles (80 ns) apart, and never closer.
- R10: With `full_duplex` high, the spacing is exactly 10 cycles (100 ns). The mode is taken at the strobe fall of the earlier access.
- R11: A request is accepted only on an edge where `req_ready` is high. `req_ready` is low from acceptance until the spacing and float windows expire, and a `req_valid` seen while `req_ready` is low starts no access.
- R12: `done` is a single-cycle pulse, high in the first cycle with `cs_n` back at 1, and occurs once per access.
- R13: A read (`req_write`=0) pulses only `rd_n` and a write (`req_write`=1) pulses only `wr_n`. The two strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 100 MHz |
| rst | input | 1 | Synchronous active-high reset |
| full_duplex | input | 1 | Selects the longer strobe spacing |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Word to write |
| req_ready | output | 1 | Request can be accepted this cycle |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Word captured by the last read |
| cs_n | output | 1 | Active-low data port select |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| bus_oe | output | 1 | Output enable for `bus_dout` |
| bus_dout | output | 32 | Outgoing data word |
| bus_din | input | 32 | Incoming data word |

## Verification
The hardest case to reach is the spacing rule at its exact limit. The limit shows only when a second request is already waiting as the timer expires, and when the duplex mode changes between the strobe that loaded the timer and the next one. The bench therefore holds `req_valid` high across accesses so that they run back to back. It measures the fall-to-fall gap against the 80 ns and 100 ns minimums in a bus model. It also flips `full_duplex` just after a strobe has fallen, which checks that the gap still follows the mode in force at that fall. A read followed at once by a write exercises the float window.

// File: rtl/dport_pkg.sv
`timescale 1ns/1ps
package dport_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_TAIL
  } phase_t;

  // Timer preload so that the next strobe can fall exactly `space` cycles
  // after the current one, given `setup` cycles between accept and strobe.
  function automatic int gap_preload(input int space, input int setup);
    return space - setup - 1;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dport_gap_timer.sv
`timescale 1ns/1ps
module dport_gap_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

  // R11: a new window is opened only after the previous one has run out
  p_load_when_clear_r11: assert property (@(posedge clk) disable iff (rst)
    load |-> zero);

endmodule

// File: rtl/dport_rd_capture.sv
`timescale 1ns/1ps
module dport_rd_capture #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sample,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (sample) begin
      q <= din;
    end
  end

endmodule

// File: rtl/dport_phase_ctrl.sv
`timescale 1ns/1ps
module dport_phase_ctrl
  import dport_pkg::*;
#(
  parameter int DW         = 32,
  parameter int SETUP_CYC  = 1,
  parameter int STROBE_CYC = 3,
  parameter int HOLD_CYC   = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  input  logic          gaps_clear,
  output logic          idle,
  output logic          strobe_fall,
  output logic          rd_sample,
  output logic          cs_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic          bus_oe,
  output logic [DW-1:0] bus_dout,
  output logic          done
);

  localparam int PH_MAX = max3(SETUP_CYC, STROBE_CYC, HOLD_CYC);
  localparam int PH_W   = $clog2(PH_MAX + 1);

  phase_t          phase_q;
  logic [PH_W-1:0] ph_cnt_q;
  logic            is_wr_q;
  logic            accept;
  logic            ph_last;

  assign idle        = (phase_q == PH_IDLE);
  assign accept      = idle && req_valid && gaps_clear;
  assign ph_last     = (ph_cnt_q == '0);
  assign strobe_fall = (phase_q == PH_SETUP) && ph_last;
  assign rd_sample   = (phase_q == PH_STROBE) && ph_last && !is_wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      ph_cnt_q <= '0;
      is_wr_q  <= 1'b0;
      cs_n     <= 1'b1;
      rd_n     <= 1'b1;
      wr_n     <= 1'b1;
      bus_oe   <= 1'b0;
      bus_dout <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (accept) begin
            cs_n     <= 1'b0;
            bus_oe   <= req_write;
            bus_dout <= req_wdata;
            is_wr_q  <= req_write;
            ph_cnt_q <= PH_W'(SETUP_CYC - 1);
            phase_q  <= PH_SETUP;
          end
        end
        PH_SETUP: begin
          if (ph_last) begin
            rd_n     <= is_wr_q;
            wr_n     <= !is_wr_q;
            ph_cnt_q <= PH_W'(STROBE_CYC - 1);
            phase_q  <= PH_STROBE;
          end else begin
            ph_cnt_q <= ph_cnt_q - 1'b1;
          end
        end
        PH_STROBE: begin
          if (ph_last) begin
            rd_n     <= 1'b1;
            wr_n     <= 1'b1;
            ph_cnt_q <= PH_W'(HOLD_CYC - 1);
            phase_q  <= PH_HOLD;
          end else begin
            ph_cnt_q <= ph_cnt_q - 1'b1;
          end
        end
        PH_HOLD: begin
          if (ph_last) begin
            cs_n    <= 1'b1;
            done    <= 1'b1;
            phase_q <= PH_TAIL;
          end else begin
            ph_cnt_q <= ph_cnt_q - 1'b1;
          end
        end
        PH_TAIL: begin
          bus_oe  <= 1'b0;
          phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // Checker-side count of consecutive strobe-low cycles
  logic [PH_W:0] low_cnt_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt_q <= '0;
    end else if (!rd_n || !wr_n) begin
      low_cnt_q <= low_cnt_q + 1'b1;
    end else begin
      low_cnt_q <= '0;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (cs_n && rd_n && wr_n && !bus_oe && !done));

  p_cs_setup_r2: assert property (@(posedge clk) disable iff (rst)
    ($fell(rd_n) || $fell(wr_n)) |-> (!cs_n && !$past(cs_n)));

  p_strobe_width_r3: assert property (@(posedge clk) disable iff (rst)
    ($rose(rd_n) || $rose(wr_n)) |-> (low_cnt_q == (PH_W+1)'(STROBE_CYC)));

  p_cs_hold_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(rd_n) || $rose(wr_n)) |-> !cs_n);

  p_wdata_stable_r6: assert property (@(posedge clk) disable iff (rst)
    (!wr_n) |-> (bus_oe && $stable(bus_dout)));

  p_oe_tail_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(cs_n) && bus_oe) |=> !bus_oe);

  p_no_oe_on_read_r8: assert property (@(posedge clk) disable iff (rst)
    (!rd_n) |-> !bus_oe);

  p_done_single_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_at_cs_rise_r12: assert property (@(posedge clk) disable iff (rst)
    done |-> $rose(cs_n));

  p_one_strobe_r13: assert property (@(posedge clk) disable iff (rst)
    (!rd_n) |-> wr_n);

endmodule

// File: rtl/dport_seq.sv
`timescale 1ns/1ps
module dport_seq
  import dport_pkg::*;
#(
  parameter int DW         = 32,
  parameter int SETUP_CYC  = 1,
  parameter int STROBE_CYC = 3,
  parameter int HOLD_CYC   = 1,
  parameter int FLOAT_CYC  = 2,
  parameter int SPACE_NORM = 8,
  parameter int SPACE_FDX  = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          full_duplex,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          cs_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic          bus_oe,
  output logic [DW-1:0] bus_dout,
  input  logic [DW-1:0] bus_din
);

  localparam int PRE_NORM = gap_preload(SPACE_NORM, SETUP_CYC);
  localparam int PRE_FDX  = gap_preload(SPACE_FDX, SETUP_CYC);
  localparam int PRE_MAX  = (PRE_NORM > PRE_FDX) ? PRE_NORM : PRE_FDX;
  localparam int SPC_W    = $clog2(PRE_MAX + 1) + 1;
  localparam int FLT_W    = $clog2(FLOAT_CYC + 1) + 1;

  logic idle, strobe_fall, rd_sample;
  logic spc_zero, flt_zero;
  logic [SPC_W-1:0] spc_load_val;

  assign req_ready    = idle && spc_zero && flt_zero;
  assign spc_load_val = full_duplex ? SPC_W'(PRE_FDX) : SPC_W'(PRE_NORM);

  dport_phase_ctrl #(
    .DW(DW), .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_wdata(req_wdata),
    .gaps_clear(spc_zero && flt_zero),
    .idle(idle), .strobe_fall(strobe_fall), .rd_sample(rd_sample),
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .bus_oe(bus_oe), .bus_dout(bus_dout), .done(done)
  );

  dport_gap_timer #(.W(SPC_W)) u_spacing (
    .clk(clk), .rst(rst), .load(strobe_fall), .load_val(spc_load_val),
    .zero(spc_zero)
  );

  dport_gap_timer #(.W(FLT_W)) u_float (
    .clk(clk), .rst(rst), .load(rd_sample), .load_val(FLT_W'(FLOAT_CYC)),
    .zero(flt_zero)
  );

  dport_rd_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst(rst), .sample(rd_sample), .din(bus_din), .q(rdata)
  );

  // R8: the bus stays undriven by the host while the peripheral may float data
  p_float_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (!flt_zero) |-> !bus_oe);

  // R11: no acceptance (select falling) without ready in the previous cycle
  p_accept_ready_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> $past(req_ready && req_valid));

endmodule

// File: tb/test_dport_seq.sv
`timescale 1ns/1ps
module test_dport_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        full_duplex = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, done, cs_n, rd_n, wr_n, bus_oe;
  logic [31:0] rdata, bus_dout;
  logic [31:0] bus_din = 32'h0BAD_F00D;

  always #5 clk = ~clk;

  dport_seq i_dport_seq (
    .clk(clk), .rst(rst), .full_duplex(full_duplex),
    .req_valid(req_valid), .req_write(req_write), .req_wdata(req_wdata),
    .req_ready(req_ready), .done(done), .rdata(rdata),
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .bus_oe(bus_oe), .bus_dout(bus_dout), .bus_din(bus_din)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- scoreboard ----------------
  typedef struct packed { logic w; logic [31:0] d; } exp_t;
  exp_t        sbq[$];
  logic [31:0] rdq[$];
  int          n_rd_issued = 0;
  int          n_wr_issued = 0;

  task automatic xfer(input bit w, input logic [31:0] d);
    @(negedge clk);
    if (!w) begin rdq.push_back(d); n_rd_issued++; end
    else n_wr_issued++;
    sbq.push_back('{w: w, d: d});
    req_valid = 1'b1;
    req_write = w;
    req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_wdata = ~d;
  endtask

  task automatic drain();
    while (sbq.size() != 0) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  // ---------------- bus model ----------------
  bit       armed = 0;
  realtime  t_cs_fall, t_cs_rise, t_fall, t_rise, t_dout_chg;
  bit       have_fall = 0;
  bit       prev_fdx = 0;
  realtime  last_gap = 0;
  bit       drv = 0;
  logic [31:0] wr_seen = '0;
  int n_cs_fall = 0, n_rd_fall = 0, n_wr_fall = 0;
  int v_setup = 0, v_width = 0, v_hold = 0, v_wsetup = 0, v_whold = 0;
  int v_oe = 0, v_float = 0, v_space = 0, v_both = 0;

  always @(bus_dout) t_dout_chg = $realtime;

  always @(negedge cs_n) if (armed) begin
    t_cs_fall = $realtime;
    n_cs_fall++;
  end

  always @(posedge cs_n) if (armed) begin
    t_cs_rise = $realtime;
    if ($realtime - t_rise < 5.0) v_hold++;
  end

  task automatic strobe_fell();
    realtime minv;
    if ($realtime - t_cs_fall < 2.0 || cs_n) v_setup++;
    if (!rd_n && !wr_n) v_both++;
    if (have_fall) begin
      minv = prev_fdx ? 100.0 : 80.0;
      last_gap = $realtime - t_fall;
      if (last_gap < minv) v_space++;
    end
    t_fall = $realtime;
    prev_fdx = full_duplex;
    have_fall = 1;
  endtask

  always @(negedge rd_n) if (armed) begin
    n_rd_fall++;
    strobe_fell();
    #25;
    if (rdq.size() != 0) bus_din = rdq.pop_front();
    drv = 1;
  end

  always @(negedge wr_n) if (armed) begin
    n_wr_fall++;
    strobe_fell();
  end

  always @(posedge rd_n) if (armed) begin
    t_rise = $realtime;
    if (t_rise - t_fall != 30.0) v_width++;
    #10;
    drv = 0;
    bus_din = 32'h0BAD_F00D;
  end

  always @(posedge wr_n) if (armed) begin
    t_rise = $realtime;
    if (t_rise - t_fall != 30.0) v_width++;
    if (!bus_oe || ($realtime - t_dout_chg < 10.0)) v_wsetup++;
    wr_seen = bus_dout;
    #5;
    if (!bus_oe || bus_dout != wr_seen) v_whold++;
  end

  always @(posedge bus_oe) if (armed) begin
    if (cs_n) v_oe++;
  end

  always @(negedge bus_oe) if (armed) begin
    if (!cs_n || ($realtime - t_cs_rise != 10.0)) v_oe++;
  end

  always @(negedge clk) if (armed && drv && bus_oe) v_float++;

  // ---------------- monitor ----------------
  bit prev_done = 0;
  always @(negedge clk) if (armed) begin
    if (done) begin
      exp_t e;
      chk(cs_n == 1'b1 && !prev_done, "R12", "done pulse placement",
          {31'd0, cs_n}, 32'd1);
      if (sbq.size() == 0) begin
        chk(1'b0, "R12", "done without request", 32'd1, 32'd0);
      end else begin
        e = sbq.pop_front();
        if (e.w) chk(wr_seen == e.d, "R6", "written word", wr_seen, e.d);
        else     chk(rdata == e.d, "R5", "read word", rdata, e.d);
      end
    end
    prev_done = done;
  end

  // ---------------- watchdog ----------------
  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    int cs_before;
    repeat (4) @(negedge clk);
    // R1: outputs idle while reset is held
    chk(cs_n && rd_n && wr_n && !bus_oe && !done, "R1", "idle in reset",
        {27'd0, cs_n, rd_n, wr_n, bus_oe, done}, 32'h1C);
    rst = 1'b0;
    armed = 1;
    @(negedge clk);
    chk(cs_n && rd_n && wr_n && !bus_oe && !done, "R1", "idle after reset",
        {27'd0, cs_n, rd_n, wr_n, bus_oe, done}, 32'h1C);
    chk(req_ready == 1'b1, "R1", "ready after reset", {31'd0, req_ready}, 32'd1);

    // Single write and read
    xfer(1'b1, 32'hAA55_1234);
    chk(req_ready == 1'b0, "R11", "ready low while busy", {31'd0, req_ready}, 32'd0);
    xfer(1'b0, 32'h1357_9BDF);
    drain();

    // R9: back-to-back reads, normal mode
    xfer(1'b0, 32'hCAFE_0001);
    xfer(1'b0, 32'hCAFE_0002);
    drain();
    chk(last_gap == 80.0, "R9", "normal spacing ns", 32'(int'(last_gap)), 32'd80);

    // R8: read followed at once by a write
    xfer(1'b0, 32'h0F0F_F0F0);
    xfer(1'b1, 32'h5A5A_A5A5);
    drain();
    chk(last_gap == 80.0, "R9", "read-write spacing ns", 32'(int'(last_gap)), 32'd80);

    // R10: full duplex spacing
    full_duplex = 1'b1;
    xfer(1'b1, 32'hDEAD_0010);
    xfer(1'b0, 32'hBEEF_0020);
    drain();
    chk(last_gap == 100.0, "R10", "duplex spacing ns", 32'(int'(last_gap)), 32'd100);

    // R10: mode taken at the earlier strobe fall
    xfer(1'b1, 32'h1111_2222);
    @(negedge clk);
    full_duplex = 1'b0;
    xfer(1'b0, 32'h3333_4444);
    drain();
    chk(last_gap == 100.0, "R10", "mode latched at fall", 32'(int'(last_gap)), 32'd100);

    // R11: request while not ready is ignored
    xfer(1'b1, 32'h7777_8888);
    cs_before = n_cs_fall;
    @(negedge clk);
    chk(req_ready == 1'b0, "R11", "ready low in spacing", {31'd0, req_ready}, 32'd0);
    req_valid = 1'b1; req_write = 1'b1; req_wdata = 32'h9999_AAAA;
    @(negedge clk);
    req_valid = 1'b0;
    drain();
    repeat (20) @(negedge clk);
    chk(n_cs_fall == cs_before, "R11", "ignored request", 32'(n_cs_fall), 32'(cs_before));
    chk(cs_n && !bus_oe, "R11", "bus idle after ignore", {30'd0, cs_n, bus_oe}, 32'd2);

    // Mixed patterns
    for (int i = 0; i < 6; i++) begin
      xfer(i[0], 32'h0100_0001 << i ^ 32'hF00F_0000);
    end
    drain();

    // Bus model rule counters
    chk(v_setup == 0, "R2", "select setup violations", 32'(v_setup), 32'd0);
    chk(v_width == 0, "R3", "strobe width violations", 32'(v_width), 32'd0);
    chk(v_hold == 0, "R4", "select hold violations", 32'(v_hold), 32'd0);
    chk(v_wsetup == 0, "R6", "write setup violations", 32'(v_wsetup), 32'd0);
    chk(v_whold == 0, "R6", "write hold violations", 32'(v_whold), 32'd0);
    chk(v_oe == 0, "R7", "output enable timing violations", 32'(v_oe), 32'd0);
    chk(v_float == 0, "R8", "enable during read or float", 32'(v_float), 32'd0);
    chk(v_space == 0, "R9", "spacing below minimum", 32'(v_space), 32'd0);
    chk(v_both == 0, "R13", "both strobes low", 32'(v_both), 32'd0);
    chk(n_rd_fall == n_rd_issued, "R13", "read strobes", 32'(n_rd_fall), 32'(n_rd_issued));
    chk(n_wr_fall == n_wr_issued, "R13", "write strobes", 32'(n_wr_fall), 32'(n_wr_issued));
    chk(sbq.size() == 0, "R12", "pending completions", 32'(sbq.size()), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule